// File: doc/BRIEF.md
# Reset and Exception Entry Controller

This block decides the moment a small processor core is forced into reset and the moment it begins a hardware exception sequence. Two sources can reset the core. The first is an asynchronous, active-low external pin, which is synchronised and must stay low for a minimum number of clocks before it counts. The second is a watchdog overflow strobe, which only has an effect when its reset option is enabled and which then holds the core in reset for a fixed stretch of clocks. When the reset state ends, the block emits a one-cycle pulse that starts the reset sequence.

Interrupt entry is gated to safe points. A pending request is taken only at an instruction boundary, or at the end of a hardware sequence that is in progress. It is also held off for one boundary when the instruction that just retired is marked as one that changes the condition or interrupt-mask flags. A busy indication covers each sequence from its start pulse to the core's done signal. Reset outranks everything: while it is active, no interrupt starts and the busy indication is cleared.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `core_rst` is high, `irq_seq_start` stays low and `seq_busy` reads 0, and a sequence that was in progress is abandoned.
- R2: When `rst_pin_n` is sampled low on at least 10 consecutive clock edges (after synchronisation), `core_rst` goes high and stays high for as long as the pin remains low.
- R3: A low pulse on `rst_pin_n` that lasts 9 or fewer clock edges has no effect: `core_rst` and `rst_seq_start` stay low.
- R4: The pin passes through a two-stage synchroniser. Once the pin returns high, `core_rst` falls after the third rising edge that samples it high.
- R5: A one-cycle `wdt_ovf` with `wdt_rst_en` = 1 drives `core_rst` high for exactly 518 cycles, starting in the cycle after the edge that samples the strobe.
- R6: A `wdt_ovf` with `wdt_rst_en` = 0 has no effect on `core_rst`.
- R7: A qualifying watchdog overflow during an active watchdog pulse restarts the 518-cycle count. Two strobes 200 cycles apart therefore give one 718-cycle reset.
- R8: An external reset that is still held low when the watchdog pulse ends keeps `core_rst` high until the pin is released. The combined reset produces a single start pulse.
- R9: `rst_seq_start` is a one-cycle pulse in the first cycle in which `core_rst` is low after having been high.
- R10: With `irq_req` = 1, `irq_seq_start` pulses in the same cycle as a boundary. When idle, the boundary is `insn_end`; while a sequence is busy, it is `seq_done`. An `insn_end` during a busy sequence is not a boundary.
- R11: An `insn_end` with `insn_masks_irq` = 1 does not start an interrupt. The request is taken at the next unmasked boundary.
- R12: `seq_busy` rises in the cycle after any start pulse and clears in the cycle after `seq_done`. A reset-sequence start takes precedence over an interrupt start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow strobe, one cycle |
| wdt_rst_en | input | 1 | Watchdog overflow causes a reset when 1 |
| irq_req | input | 1 | Pending interrupt request (already prioritised) |
| insn_end | input | 1 | Instruction retires this cycle |
| insn_masks_irq | input | 1 | Retiring instruction modified the flag register; blocks interrupt recognition at this boundary |
| seq_done | input | 1 | Current hardware sequence finishes this cycle |
| core_rst | output | 1 | Synchronous reset to the core, active high |
| rst_seq_start | output | 1 | One-cycle start of the reset sequence |
| irq_seq_start | output | 1 | One-cycle start of the interrupt sequence |
| seq_busy | output | 1 | A hardware sequence is in progress |

## Verification
The bench drives the pin low for exactly 9 and then exactly 10 clocks. A qualifier with a counter off by one would either reset the core on the short pulse or miss the minimal valid one. It checks the 518- and 718-cycle watchdog reset lengths, which catch a pulse length that is off by one and a second overflow that is ignored instead of restarting the count. It also holds the external pin across the end of a watchdog pulse, which catches a reset that drops early or a doubled start pulse.

On the interrupt side, the bench presents a masked boundary followed by an unmasked one. It presents an instruction boundary while a sequence is busy, then a chained request at sequence end, and it lifts reset while an interrupt is in progress. A design that ignores the mask flag, takes interrupts in mid-sequence, or lets busy survive a reset fails one of these checks.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int DEF_SYNC_STAGES = 2;
   localparam int DEF_QUAL_CYCLES = 10;
   localparam int DEF_WDT_PULSE   = 518;

   // start strobes from the entry arbiter
   typedef struct packed {
      logic rst_go;
      logic irq_go;
   } seq_go_t;

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYCLES = 10
) (
   input  logic clk,
   input  logic pin_n,
   output logic ext_rst
);
   localparam int CW = $clog2(QUAL_CYCLES + 1);
   localparam logic [CW-1:0] QMAX = CW'(QUAL_CYCLES);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rst_pin_qual: SYNC_STAGES must be at least 2");
      end
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("rst_pin_qual: QUAL_CYCLES must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_lo;
   logic [CW-1:0]          lo_cnt;

   // synchroniser chain, oldest sample at the top
   always_ff @(posedge clk) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
   end

   assign pin_lo = ~sync_q[SYNC_STAGES-1];

   // consecutive-low counter, saturating at the qualification limit
   always_ff @(posedge clk) begin
      if (!pin_lo) begin
         lo_cnt <= '0;
      end else if (lo_cnt != QMAX) begin
         lo_cnt <= lo_cnt + CW'(1);
      end
   end

   assign ext_rst = (lo_cnt == QMAX);

   // R3: the counter never passes its limit
   always_comb begin
      a_r3_cnt_saturates: assert (lo_cnt <= QMAX);
   end

   // R2: once qualified, the reset holds while the pin stays low
   a_r2_hold_while_low: assert property (@(posedge clk) disable iff (!pin_lo)
      ext_rst |=> ext_rst);

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
   parameter int PULSE          = 518,
   parameter bit RESTART_ON_OVF = 1'b1
) (
   input  logic clk,
   input  logic ext_rst,
   input  logic wdt_ovf,
   input  logic wdt_rst_en,
   output logic wdt_rst
);
   localparam int CW = $clog2(PULSE + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE);

   logic [CW-1:0] left_q;
   logic          fire;
   logic          load;

   assign fire = wdt_ovf & wdt_rst_en;

   generate
      if (PULSE < 1) begin : g_bad_pulse
         $error("wdt_rst_stretch: PULSE must be at least 1");
      end
      if (RESTART_ON_OVF) begin : g_restart
         assign load = fire;
         // R7: every qualifying overflow reloads the full count
         a_r7_reload: assert property (@(posedge clk) disable iff (ext_rst)
            fire |=> (left_q == CNT_LOAD));
      end else begin : g_oneshot
         assign load = fire & (left_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (load) begin
         left_q <= CNT_LOAD;
      end else if (left_q != '0) begin
         left_q <= left_q - CW'(1);
      end
   end

   assign wdt_rst = (left_q != '0);

   // R6: without an enabled overflow an idle stretcher stays idle
   a_r6_en_gate: assert property (@(posedge clk) disable iff (ext_rst)
      (!wdt_rst && !fire) |=> !wdt_rst);

   // R5: an active pulse counts down by exactly one per clock
   a_r5_count_down: assert property (@(posedge clk) disable iff (ext_rst)
      (wdt_rst && !fire) |=> (left_q == $past(left_q) - CW'(1)));

endmodule

// File: rtl/exc_seq_arb.sv
module exc_seq_arb
   import exc_entry_pkg::*;
(
   input  logic    clk,
   input  logic    core_rst,
   input  logic    irq_req,
   input  logic    insn_end,
   input  logic    insn_masks_irq,
   input  logic    seq_done,
   output seq_go_t go,
   output logic    busy_q
);
   logic rst_prev_q;
   logic at_boundary;

   always_ff @(posedge clk) begin
      rst_prev_q <= core_rst;
   end

   always_comb begin
      at_boundary = busy_q ? seq_done : (insn_end & ~insn_masks_irq);
      go.rst_go   = rst_prev_q & ~core_rst;
      go.irq_go   = ~core_rst & ~go.rst_go & irq_req & at_boundary;
   end

   always_ff @(posedge clk) begin
      if (core_rst) begin
         busy_q <= 1'b0;
      end else if (go.rst_go || go.irq_go) begin
         busy_q <= 1'b1;
      end else if (seq_done) begin
         busy_q <= 1'b0;
      end
   end

   // R1: any reset has cleared the busy state before the reset sequence starts
   always_comb begin
      if (go.rst_go) begin
         a_r1_clear_before_start: assert (!busy_q);
      end
   end

   // R12: at most one start per cycle
   a_r12_one_start: assert property (@(posedge clk) disable iff (core_rst)
      $onehot0({go.rst_go, go.irq_go}));

   // R12: every start marks the core busy
   a_r12_busy_set: assert property (@(posedge clk) disable iff (core_rst)
      (go.rst_go || go.irq_go) |=> busy_q);

   // R9: the reset-sequence start never lasts two cycles
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (core_rst)
      go.rst_go |=> !go.rst_go);

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int QUAL_CYCLES = DEF_QUAL_CYCLES,
   parameter int WDT_PULSE   = DEF_WDT_PULSE,
   parameter bit WDT_RESTART = 1'b1
) (
   input  logic clk,
   input  logic rst_pin_n,
   input  logic wdt_ovf,
   input  logic wdt_rst_en,
   input  logic irq_req,
   input  logic insn_end,
   input  logic insn_masks_irq,
   input  logic seq_done,
   output logic core_rst,
   output logic rst_seq_start,
   output logic irq_seq_start,
   output logic seq_busy
);
   logic    ext_rst;
   logic    wdt_rst;
   logic    busy_q;
   seq_go_t go;

   rst_pin_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .QUAL_CYCLES (QUAL_CYCLES)
   ) u_pin (
      .clk     (clk),
      .pin_n   (rst_pin_n),
      .ext_rst (ext_rst)
   );

   wdt_rst_stretch #(
      .PULSE          (WDT_PULSE),
      .RESTART_ON_OVF (WDT_RESTART)
   ) u_wdt (
      .clk        (clk),
      .ext_rst    (ext_rst),
      .wdt_ovf    (wdt_ovf),
      .wdt_rst_en (wdt_rst_en),
      .wdt_rst    (wdt_rst)
   );

   assign core_rst = ext_rst | wdt_rst;

   exc_seq_arb u_arb (
      .clk            (clk),
      .core_rst       (core_rst),
      .irq_req        (irq_req),
      .insn_end       (insn_end),
      .insn_masks_irq (insn_masks_irq),
      .seq_done       (seq_done),
      .go             (go),
      .busy_q         (busy_q)
   );

   assign rst_seq_start = go.rst_go;
   assign irq_seq_start = go.irq_go;
   assign seq_busy      = busy_q & ~core_rst;

   // R1: reset blocks interrupt entry
   always_comb begin
      if (core_rst) begin
         a_r1_no_irq_in_rst: assert (!irq_seq_start);
      end
   end

   // R9: a reset-sequence start follows a reset cycle
   a_r9_after_rst: assert property (@(posedge clk) disable iff (core_rst)
      rst_seq_start |-> $past(core_rst));

   // R10: an interrupt start needs a request and a boundary strobe
   a_r10_at_boundary: assert property (@(posedge clk) disable iff (core_rst)
      irq_seq_start |-> (irq_req && (insn_end || seq_done)));

   // R11: a masked instruction boundary never starts an interrupt
   a_r11_masked: assert property (@(posedge clk) disable iff (core_rst)
      (insn_end && insn_masks_irq && !seq_busy) |-> !irq_seq_start);

endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
   localparam int CLK_NS = 20;
   localparam int QUAL   = 10;
   localparam int PULSE  = 518;

   logic clk = 1'b0;
   logic rst_pin_n = 1'b0, wdt_ovf = 1'b0, wdt_rst_en = 1'b0, irq_req = 1'b0;
   logic insn_end = 1'b0, insn_masks_irq = 1'b0, seq_done = 1'b0;
   logic core_rst, rst_seq_start, irq_seq_start, seq_busy;

   exc_entry_ctrl dut (
      .clk(clk), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf), .wdt_rst_en(wdt_rst_en),
      .irq_req(irq_req), .insn_end(insn_end), .insn_masks_irq(insn_masks_irq),
      .seq_done(seq_done), .core_rst(core_rst), .rst_seq_start(rst_seq_start),
      .irq_seq_start(irq_seq_start), .seq_busy(seq_busy)
   );

   always #(CLK_NS/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int cyc = 0, run = 0, last_run = 0, tot_hi = 0;
   int n_rs = 0, n_is = 0, last_rs_cyc = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural reference model, compared every cycle just before the edge
   bit m_s0 = 1'b0, m_s1 = 1'b0, m_prev = 1'b0, m_busy = 1'b0, armed = 1'b0;
   int m_low = 0, m_wdt = 0;
   initial begin
      forever begin
         bit e_rst, e_rs, e_is, e_busy, bnd;
         @(negedge clk);
         #8;
         cyc++;
         e_rst  = (m_low >= QUAL) || (m_wdt > 0);
         e_rs   = m_prev && !e_rst;
         bnd    = m_busy ? seq_done : (insn_end && !insn_masks_irq);
         e_is   = !e_rst && !e_rs && irq_req && bnd;
         e_busy = m_busy && !e_rst;
         if (e_rs) armed = 1'b1;
         if (armed) begin
            chk(core_rst == e_rst, "R2 model core_rst", core_rst, e_rst);
            chk(rst_seq_start == e_rs, "R9 model rst_seq_start", rst_seq_start, e_rs);
            chk(irq_seq_start == e_is, "R10 model irq_seq_start", irq_seq_start, e_is);
            chk(seq_busy == e_busy, "R12 model seq_busy", seq_busy, e_busy);
         end
         // observation counters from the ports
         if (core_rst) begin run++; tot_hi++; end
         else if (run > 0) begin last_run = run; run = 0; end
         if (rst_seq_start) begin n_rs++; last_rs_cyc = cyc; end
         if (irq_seq_start) n_is++;
         // advance model state
         if (!m_s1) m_low = (m_low < QUAL) ? m_low + 1 : m_low;
         else       m_low = 0;
         m_s1 = m_s0;
         m_s0 = rst_pin_n;
         if (wdt_ovf && wdt_rst_en) m_wdt = PULSE;
         else if (m_wdt > 0)        m_wdt--;
         if (e_rst)              m_busy = 1'b0;
         else if (e_rs || e_is)  m_busy = 1'b1;
         else if (seq_done)      m_busy = 1'b0;
         m_prev = e_rst;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic done_pulse();
      seq_done = 1'b1; tick(); seq_done = 1'b0; tick();
   endtask

   task automatic wdt_pulse();
      wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
   endtask

   bit finished = 1'b0;
   initial begin
      #(CLK_NS * 150000);
      if (!finished) begin
         chk(1'b0, "watchdog timeout", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int base, k0, t0;
      // power-on reset through the pin
      repeat (30) tick();
      chk(core_rst == 1'b1, "R2 reset after long low", core_rst, 1);
      chk(seq_busy == 1'b0, "R1 busy cleared in reset", seq_busy, 0);
      base = cyc;
      rst_pin_n = 1'b1;
      repeat (6) tick();
      chk(last_rs_cyc - base == 4, "R4 release latency", last_rs_cyc - base, 4);
      chk(n_rs == 1, "R9 one reset start", n_rs, 1);
      chk(seq_busy == 1'b1, "R12 busy after reset start", seq_busy, 1);
      done_pulse();
      chk(seq_busy == 1'b0, "R12 busy cleared by done", seq_busy, 0);

      // masked boundary then unmasked boundary
      k0 = n_is;
      irq_req = 1'b1; insn_end = 1'b1; insn_masks_irq = 1'b1; tick();
      insn_end = 1'b0; insn_masks_irq = 1'b0; tick(); tick();
      chk(n_is == k0, "R11 masked boundary ignored", n_is, k0);
      insn_end = 1'b1; tick(); insn_end = 1'b0; tick();
      chk(n_is == k0 + 1, "R11 deferred to next boundary", n_is, k0 + 1);
      chk(seq_busy == 1'b1, "R12 busy after irq start", seq_busy, 1);
      insn_end = 1'b1; tick(); insn_end = 1'b0; tick();
      chk(n_is == k0 + 1, "R10 no entry mid-sequence", n_is, k0 + 1);
      done_pulse();
      chk(n_is == k0 + 2, "R10 chained at sequence end", n_is, k0 + 2);
      irq_req = 1'b0;
      done_pulse();
      chk(seq_busy == 1'b0, "R12 idle after last done", seq_busy, 0);

      // short and minimal pin pulses
      t0 = tot_hi; k0 = n_rs;
      rst_pin_n = 1'b0; repeat (9) tick(); rst_pin_n = 1'b1; repeat (15) tick();
      chk(tot_hi == t0, "R3 nine-clock pulse ignored", tot_hi, t0);
      chk(n_rs == k0, "R3 no start from short pulse", n_rs, k0);
      rst_pin_n = 1'b0; repeat (10) tick(); rst_pin_n = 1'b1; repeat (15) tick();
      chk(tot_hi == t0 + 1, "R2 ten-clock pulse qualifies", tot_hi, t0 + 1);
      chk(n_rs == k0 + 1, "R9 start after minimal reset", n_rs, k0 + 1);
      done_pulse();

      // watchdog without reset option
      t0 = tot_hi;
      wdt_rst_en = 1'b0; wdt_pulse(); repeat (5) tick();
      chk(tot_hi == t0, "R6 disabled overflow ignored", tot_hi, t0);

      // watchdog reset aborting an interrupt sequence
      irq_req = 1'b1; insn_end = 1'b1; tick(); insn_end = 1'b0; irq_req = 1'b0; tick();
      chk(seq_busy == 1'b1, "R12 busy before watchdog", seq_busy, 1);
      wdt_rst_en = 1'b1; wdt_pulse(); tick();
      k0 = n_is;
      irq_req = 1'b1; insn_end = 1'b1; repeat (4) tick();
      chk(n_is == k0, "R1 no irq start in reset", n_is, k0);
      chk(seq_busy == 1'b0, "R1 busy dropped by reset", seq_busy, 0);
      irq_req = 1'b0; insn_end = 1'b0;
      repeat (530) tick();
      chk(last_run == PULSE, "R5 watchdog pulse length", last_run, PULSE);
      done_pulse();

      // restart on second overflow
      wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
      repeat (199) tick();
      wdt_pulse();
      repeat (730) tick();
      chk(last_run == PULSE + 200, "R7 restarted pulse length", last_run, PULSE + 200);
      done_pulse();

      // external reset held beyond the watchdog pulse
      k0 = n_rs;
      wdt_pulse(); repeat (50) tick();
      rst_pin_n = 1'b0; repeat (600) tick();
      chk(core_rst == 1'b1, "R8 reset held past watchdog", core_rst, 1);
      rst_pin_n = 1'b1; repeat (10) tick();
      chk(last_run > 600, "R8 combined reset length", last_run, 601);
      chk(n_rs == k0 + 1, "R8 single start for combined reset", n_rs, k0 + 1);
      done_pulse();
      repeat (5) tick();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule